// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block keeps one private, write-back, direct-mapped cache coherent with its peers on a shared snooping bus. Every line is Invalid, Shared (clean, possibly held elsewhere) or Modified (dirty and held only here). The local core issues reads and writes through a request/ready handshake. The controller answers hits at once. Misses, upgrades and evictions go out as bus transactions, and the core waits for them.

The controller also watches every transaction that other caches place on the bus. A foreign invalidate that matches a resident line removes that line. A foreign read that matches a dirty line makes this cache return the data on its supply output and drop the line to Shared. Before any local write changes a line, the cache must first own it through a granted invalidate. Dirty data leaves the cache only when a peer asks for it or when the line is evicted.

Top module: `snoop_wi_cache`

## Requirements
- R1: After reset every line is Invalid, busReq, supValid and coreReady are low, and the first read of any address misses.
- R2: A read miss drives busReq with busCmd=2'b01 (read) and the request address, and holds it until busGrant. In the grant cycle coreReady is high and coreRdata equals busRdata. The line then becomes Shared, so a later read of that address completes in its first cycle without a bus request.
- R3: A write to a Shared line issues busCmd=2'b10 (invalidate) for the address. The write completes in the grant cycle, and the line becomes Modified.
- R4: A write to a Modified line completes in its first cycle with no bus request.
- R5: A write miss first fills the line with a read (2'b01) and then invalidates (2'b10), in that order, before it completes.
- R6: A snooped read (snpCmd=2'b01) that hits a Modified line raises supValid one cycle later, with supAddr and supData carrying the line. The line drops to Shared, so the next local write needs an invalidate again.
- R7: A snooped invalidate (snpCmd=2'b10) that hits a resident line makes it Invalid, so the next local read misses. A snooped read that hits a Shared line produces no supply.
- R8: A snoop whose tag does not match the resident line, or whose command is write-back (2'b11), changes nothing.
- R9: Evicting a Modified line issues a write-back (busCmd=2'b11) with the victim's address and data before the read of the new line.
- R10: Evicting a Shared line issues no write-back and goes straight to the read.
- R11: In a cycle where a snoop hits the index of a pending idle-state core request, the core request is not acknowledged. It is served in a later cycle against the post-snoop state. Snoops never coincide with busGrant.
- R12: If the line is invalidated while its upgrade invalidate waits for a grant, the controller abandons the upgrade. It re-reads the line (2'b01) and then invalidates it (2'b10) before completing the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreReq | input | 1 | Core request pending, held until coreReady |
| coreWrite | input | 1 | 1 = write, 0 = read |
| coreAddr | input | AddrW | Word address of the request |
| coreWdata | input | DataW | Write data |
| coreReady | output | 1 | Request completes this cycle |
| coreRdata | output | DataW | Read data, valid with coreReady |
| busReq | output | 1 | Bus transaction requested |
| busCmd | output | 2 | 01 read, 10 invalidate, 11 write-back |
| busAddr | output | AddrW | Transaction address |
| busWdata | output | DataW | Write-back data |
| busGrant | input | 1 | Transaction completes this cycle |
| busRdata | input | DataW | Fill data, valid with busGrant on a read |
| snpValid | input | 1 | A foreign transaction is on the bus |
| snpCmd | input | 2 | Foreign command, same encoding as busCmd |
| snpAddr | input | AddrW | Foreign transaction address |
| supValid | output | 1 | Dirty data is being supplied |
| supAddr | output | AddrW | Address of supplied line |
| supData | output | DataW | Supplied data |

## Verification
A line left in the wrong state shows up at the ports on its next use. A stale Shared or Modified copy returns old data on the next read, which is compared against the bench's record of the latest coherent value. A missed downgrade lets a later write complete silently with no invalidate. A lost Modified state skips the write-back or the supply, and wrong write-back or supply data is caught in the cycle it appears. Checks on the order of granted commands expose wrong miss, upgrade or eviction sequencing within a single request.

// File: rtl/snoop_wi_pkg.sv
package snoop_wi_pkg;
  typedef enum logic [1:0] {
    LINE_I = 2'b00,
    LINE_S = 2'b01,
    LINE_M = 2'b10
  } lineState_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_INV   = 2'b10,
    CMD_WBACK = 2'b11
  } busCmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_UPGRADE
  } ctlState_e;

  // strobes from control to the line store
  typedef struct packed {
    logic fillEn;   // load tag/data from bus, state Shared
    logic writeEn;  // store core data, state Modified
    logic dropEn;   // force core-indexed line Invalid
    logic fillSel;  // core read data comes from the bus
  } lineStrobe_t;
endpackage

// File: rtl/wi_line_store.sv
module wi_line_store
  import snoop_wi_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int DataW = 16,
  parameter int Lines = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lineStrobe_t              strobe,
  input  logic [AddrW-1:0]         coreAddr,
  input  logic [DataW-1:0]         coreWdata,
  input  logic [DataW-1:0]         busRdata,
  input  logic                     busGrant,
  input  logic                     snpValid,
  input  logic [1:0]               snpCmd,
  input  logic [AddrW-1:0]         snpAddr,
  output lineState_e               lineSt,
  output logic [AddrW-$clog2(Lines)-1:0] lineTag,
  output logic [DataW-1:0]         lineData,
  output logic                     coreHit,
  output logic                     snoopOnCore,
  output logic [DataW-1:0]         coreRdata,
  output logic                     supValid,
  output logic [AddrW-1:0]         supAddr,
  output logic [DataW-1:0]         supData
);
  localparam int IdxW = $clog2(Lines);
  localparam int TagW = AddrW - IdxW;

  lineState_e           stateArr [Lines];
  logic [TagW-1:0]      tagArr   [Lines];
  logic [DataW-1:0]     dataArr  [Lines];

  logic [IdxW-1:0] cIdx, sIdx;
  logic [TagW-1:0] cTag, sTag;
  busCmd_e         sCmd;
  logic            snpHit, snpRead, snpKill;

  assign cIdx = coreAddr[IdxW-1:0];
  assign cTag = coreAddr[AddrW-1:IdxW];
  assign sIdx = snpAddr[IdxW-1:0];
  assign sTag = snpAddr[AddrW-1:IdxW];
  assign sCmd = busCmd_e'(snpCmd);

  assign snpHit  = snpValid && (stateArr[sIdx] != LINE_I) && (tagArr[sIdx] == sTag);
  assign snpRead = snpHit && (sCmd == CMD_READ);
  assign snpKill = snpHit && (sCmd == CMD_INV);

  assign lineSt      = stateArr[cIdx];
  assign lineTag     = tagArr[cIdx];
  assign lineData    = dataArr[cIdx];
  assign coreHit     = (stateArr[cIdx] != LINE_I) && (tagArr[cIdx] == cTag);
  assign snoopOnCore = snpHit && (sIdx == cIdx);
  assign coreRdata   = strobe.fillSel ? busRdata : dataArr[cIdx];

  for (genvar g = 0; g < Lines; g++) begin : gLine
    logic coreSel, snpSel;
    assign coreSel = (cIdx == IdxW'(g));
    assign snpSel  = (sIdx == IdxW'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateArr[g] <= LINE_I;
        tagArr[g]   <= '0;
        dataArr[g]  <= '0;
      end else if (strobe.fillEn && coreSel) begin
        stateArr[g] <= LINE_S;
        tagArr[g]   <= cTag;
        dataArr[g]  <= busRdata;
      end else if (strobe.writeEn && coreSel) begin
        stateArr[g] <= LINE_M;
        dataArr[g]  <= coreWdata;
      end else if (strobe.dropEn && coreSel) begin
        stateArr[g] <= LINE_I;
      end else if (snpKill && snpSel) begin
        stateArr[g] <= LINE_I;
      end else if (snpRead && snpSel && stateArr[g] == LINE_M) begin
        stateArr[g] <= LINE_S;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supValid <= 1'b0;
      supAddr  <= '0;
      supData  <= '0;
    end else begin
      supValid <= snpRead && (stateArr[sIdx] == LINE_M);
      supAddr  <= snpAddr;
      supData  <= dataArr[sIdx];
    end
  end

  // supply only follows a snoop, and the supplier has given up ownership
  p_supply_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    supValid |-> $past(snpValid) && $past(snpAddr) == supAddr);
  p_supply_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    supValid |-> stateArr[supAddr[IdxW-1:0]] != LINE_M);
  // a matching foreign invalidate leaves the line Invalid
  p_snoop_kill_r7: assert property (@(posedge clk) disable iff (!rstN)
    snpKill |=> stateArr[$past(sIdx)] == LINE_I);
  // only a resident line is ever written
  p_write_owned_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |-> coreHit);
  // bus serialises: a foreign transaction never overlaps our own grant
  p_bus_serial_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(busGrant && snpValid));
endmodule

// File: rtl/wi_ctrl_fsm.sv
module wi_ctrl_fsm
  import snoop_wi_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int DataW = 16,
  parameter int Lines = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     coreReq,
  input  logic                     coreWrite,
  input  logic [AddrW-1:0]         coreAddr,
  input  lineState_e               lineSt,
  input  logic [AddrW-$clog2(Lines)-1:0] lineTag,
  input  logic [DataW-1:0]         lineData,
  input  logic                     coreHit,
  input  logic                     snoopOnCore,
  input  logic                     busGrant,
  output lineStrobe_t              strobe,
  output logic                     coreReady,
  output logic                     busReq,
  output logic [1:0]               busCmd,
  output logic [AddrW-1:0]         busAddr,
  output logic [DataW-1:0]         busWdata
);
  localparam int IdxW = $clog2(Lines);

  ctlState_e state, nextState;
  busCmd_e   cmd;

  always_comb begin
    nextState = state;
    strobe    = '0;
    coreReady = 1'b0;
    busReq    = 1'b0;
    cmd       = CMD_NONE;
    busAddr   = coreAddr;
    busWdata  = lineData;
    unique case (state)
      ST_IDLE: begin
        if (coreReq && !snoopOnCore) begin
          if (coreHit) begin
            if (!coreWrite) begin
              coreReady = 1'b1;
            end else if (lineSt == LINE_M) begin
              strobe.writeEn = 1'b1;
              coreReady      = 1'b1;
            end else begin
              nextState = ST_UPGRADE;
            end
          end else if (lineSt == LINE_M) begin
            nextState = ST_WBACK;
          end else begin
            strobe.dropEn = 1'b1;
            nextState     = ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        if (lineSt != LINE_M) begin
          // a peer already took the dirty data; nothing left to write back
          strobe.dropEn = 1'b1;
          nextState     = ST_FILL;
        end else begin
          busReq  = 1'b1;
          cmd     = CMD_WBACK;
          busAddr = {lineTag, coreAddr[IdxW-1:0]};
          if (busGrant) begin
            strobe.dropEn = 1'b1;
            nextState     = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        busReq = 1'b1;
        cmd    = CMD_READ;
        if (busGrant) begin
          strobe.fillEn  = 1'b1;
          strobe.fillSel = 1'b1;
          if (coreWrite) begin
            nextState = ST_UPGRADE;
          end else begin
            coreReady = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_UPGRADE: begin
        if (!coreHit) begin
          nextState = ST_FILL;
        end else begin
          busReq = 1'b1;
          cmd    = CMD_INV;
          if (busGrant) begin
            strobe.writeEn = 1'b1;
            coreReady      = 1'b1;
            nextState      = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busCmd = cmd;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  p_ready_has_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    coreReady |-> coreReq);
  p_read_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busCmd == CMD_READ && !busGrant |=>
      busReq && busCmd == CMD_READ && $stable(busAddr));
  p_wback_then_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busCmd == CMD_WBACK && busGrant |=> busReq && busCmd == CMD_READ);
  p_inv_completes_r3: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busCmd == CMD_INV && busGrant |-> coreReady && coreWrite);
  p_silent_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    coreReady && state == ST_IDLE |-> !busReq);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !busReq);
endmodule

// File: rtl/snoop_wi_cache.sv
module snoop_wi_cache
  import snoop_wi_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int DataW = 16,
  parameter int Lines = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreReq,
  input  logic             coreWrite,
  input  logic [AddrW-1:0] coreAddr,
  input  logic [DataW-1:0] coreWdata,
  output logic             coreReady,
  output logic [DataW-1:0] coreRdata,
  output logic             busReq,
  output logic [1:0]       busCmd,
  output logic [AddrW-1:0] busAddr,
  output logic [DataW-1:0] busWdata,
  input  logic             busGrant,
  input  logic [DataW-1:0] busRdata,
  input  logic             snpValid,
  input  logic [1:0]       snpCmd,
  input  logic [AddrW-1:0] snpAddr,
  output logic             supValid,
  output logic [AddrW-1:0] supAddr,
  output logic [DataW-1:0] supData
);
  localparam int TagW = AddrW - $clog2(Lines);

  lineStrobe_t     strobe;
  lineState_e      lineSt;
  logic [TagW-1:0] lineTag;
  logic [DataW-1:0] lineData;
  logic            coreHit, snoopOnCore;

  wi_line_store #(.AddrW(AddrW), .DataW(DataW), .Lines(Lines)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .coreAddr(coreAddr), .coreWdata(coreWdata), .busRdata(busRdata),
    .busGrant(busGrant), .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .lineSt(lineSt), .lineTag(lineTag), .lineData(lineData),
    .coreHit(coreHit), .snoopOnCore(snoopOnCore), .coreRdata(coreRdata),
    .supValid(supValid), .supAddr(supAddr), .supData(supData)
  );

  wi_ctrl_fsm #(.AddrW(AddrW), .DataW(DataW), .Lines(Lines)) uCtrl (
    .clk(clk), .rstN(rstN), .coreReq(coreReq), .coreWrite(coreWrite),
    .coreAddr(coreAddr), .lineSt(lineSt), .lineTag(lineTag), .lineData(lineData),
    .coreHit(coreHit), .snoopOnCore(snoopOnCore), .busGrant(busGrant),
    .strobe(strobe), .coreReady(coreReady), .busReq(busReq), .busCmd(busCmd),
    .busAddr(busAddr), .busWdata(busWdata)
  );
endmodule

// File: tb/snoop_wi_cache_test.sv
module snoop_wi_cache_test;
  localparam int ClkPeriod = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [1:0] RD = 2'b01, INV = 2'b10, WB = 2'b11;

  logic clk = 0, rstN = 0;
  logic coreReq = 0, coreWrite = 0;
  logic [AW-1:0] coreAddr = 0;
  logic [DW-1:0] coreWdata = 0;
  logic coreReady;
  logic [DW-1:0] coreRdata;
  logic busReq;
  logic [1:0] busCmd;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic busGrant = 0;
  logic [DW-1:0] busRdata = 0;
  logic snpValid = 0;
  logic [1:0] snpCmd = 0;
  logic [AW-1:0] snpAddr = 0;
  logic supValid;
  logic [AW-1:0] supAddr;
  logic [DW-1:0] supData;

  snoop_wi_cache uut (.*);

  always #(ClkPeriod/2) clk = ~clk;

  int nChecks = 0, nFail = 0, supCnt = 0;
  logic [DW-1:0] glob [256];
  logic [7:0] grantSeq;
  logic [DW-1:0] lastRd;
  int readyCyc, waitCnt;
  bit holdGrant = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] initVal(input int a);
    return DW'(a * 257) ^ 16'h5A5A;
  endfunction

  // supply monitor: supplied data must be the latest coherent value (R6)
  always @(negedge clk) begin
    #3;
    if (rstN && supValid) begin
      supCnt++;
      chk(supData == glob[supAddr], "R6 supply data", supData, glob[supAddr]);
    end
  end

  task automatic startCore(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    coreReq = 1; coreWrite = wr; coreAddr = a; coreWdata = d;
    waitCnt = $urandom % 3;
  endtask

  task automatic finishCore();
    bit done = 0;
    int nCyc = 0;
    grantSeq = 0;
    while (!done && nCyc < 200) begin
      #1;
      if (busReq && !holdGrant) begin
        if (waitCnt == 0) begin
          busGrant = 1;
          busRdata = glob[busAddr];
          grantSeq = {grantSeq[5:0], busCmd};
          if (busCmd == WB)
            chk(busWdata == glob[busAddr], "R9 write-back data", busWdata, glob[busAddr]);
          waitCnt = $urandom % 3;
        end else waitCnt--;
      end
      #1;
      if (coreReady) begin
        done = 1;
        lastRd = coreRdata;
        readyCyc = nCyc;
        if (coreWrite) glob[coreAddr] = coreWdata;
      end
      @(posedge clk); @(negedge clk);
      busGrant = 0;
      if (done) coreReq = 0;
      nCyc++;
    end
    if (!done) chk(0, "core request hung", 0, 1);
  endtask

  task automatic coreOp(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    startCore(wr, a, d);
    finishCore();
  endtask

  task automatic snoopOne(input logic [1:0] c, input logic [AW-1:0] a);
    snpValid = 1; snpCmd = c; snpAddr = a;
    @(posedge clk); @(negedge clk);
    snpValid = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic otherWrite(input logic [AW-1:0] a, input logic [DW-1:0] v);
    snoopOne(RD, a);
    snoopOne(INV, a);
    glob[a] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    int sBefore;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) glob[i] = initVal(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    // R1: reset state
    chk(!busReq && !supValid && !coreReady, "R1 reset outputs", {busReq, supValid, coreReady}, 0);

    // R1/R2: first read misses, fills
    coreOp(0, 8'h10, 0);
    chk(grantSeq == {6'b0, RD}, "R1 first read misses", grantSeq, RD);
    chk(lastRd == glob[8'h10], "R2 fill data", lastRd, glob[8'h10]);
    coreOp(0, 8'h10, 0);
    chk(grantSeq == 0 && readyCyc == 0, "R2 read hit silent", grantSeq, 0);

    // R3: write to Shared upgrades
    coreOp(1, 8'h10, 16'h00A5);
    chk(grantSeq == {6'b0, INV}, "R3 upgrade invalidate", grantSeq, INV);
    // R4: write to Modified is silent
    coreOp(1, 8'h10, 16'h005A);
    chk(grantSeq == 0 && readyCyc == 0, "R4 silent write", grantSeq, 0);
    coreOp(0, 8'h10, 0);
    chk(lastRd == 16'h005A, "R4 data kept", lastRd, 16'h005A);

    // R6: snooped read on Modified supplies and downgrades
    sBefore = supCnt;
    snoopOne(RD, 8'h10);
    chk(supCnt == sBefore + 1, "R6 supply raised", supCnt, sBefore + 1);
    coreOp(1, 8'h10, 16'h0077);
    chk(grantSeq == {6'b0, INV}, "R6 downgraded to Shared", grantSeq, INV);

    // R7: foreign write invalidates, next read misses with new value
    otherWrite(8'h10, 16'h1234);
    coreOp(0, 8'h10, 0);
    chk(grantSeq == {6'b0, RD}, "R7 miss after invalidate", grantSeq, RD);
    chk(lastRd == 16'h1234, "R7 new value", lastRd, 16'h1234);
    sBefore = supCnt;
    snoopOne(RD, 8'h10);
    chk(supCnt == sBefore, "R7 no supply from Shared", supCnt, sBefore);

    // R8: tag mismatch and write-back snoops change nothing
    snoopOne(INV, 8'h30);
    snoopOne(WB, 8'h10);
    coreOp(0, 8'h10, 0);
    chk(grantSeq == 0 && lastRd == 16'h1234, "R8 snoop ignored", grantSeq, 0);

    // R10: evict Shared
    coreOp(0, 8'h20, 0);
    chk(grantSeq == {6'b0, RD}, "R10 no write-back", grantSeq, RD);
    // R9: evict Modified
    coreOp(1, 8'h20, 16'hC0DE);
    coreOp(0, 8'h40, 0);
    chk(grantSeq == {4'b0, WB, RD}, "R9 write-back then read", grantSeq, {WB, RD});
    chk(lastRd == glob[8'h40], "R9 new line data", lastRd, glob[8'h40]);
    coreOp(0, 8'h20, 0);
    chk(lastRd == 16'hC0DE, "R9 written-back value", lastRd, 16'hC0DE);

    // R5: write miss
    coreOp(1, 8'h51, 16'hBEAD);
    chk(grantSeq == {4'b0, RD, INV}, "R5 read then invalidate", grantSeq, {RD, INV});
    coreOp(0, 8'h51, 0);
    chk(lastRd == 16'hBEAD && grantSeq == 0, "R5 owned data", lastRd, 16'hBEAD);

    // R11: snoop collides with core request on same index
    startCore(0, 8'h51, 0);
    snpValid = 1; snpCmd = RD; snpAddr = 8'h51;
    #1;
    chk(!coreReady, "R11 stall on collision", coreReady, 0);
    @(posedge clk); @(negedge clk);
    snpValid = 0;
    finishCore();
    chk(lastRd == 16'hBEAD && grantSeq == 0, "R11 served after snoop", lastRd, 16'hBEAD);

    // R12: upgrade lost to a foreign invalidate
    coreOp(0, 8'h62, 0);
    holdGrant = 1;
    startCore(1, 8'h62, 16'h7777);
    @(posedge clk); @(negedge clk);
    #1;
    chk(busReq && busCmd == INV, "R12 upgrade pending", {busReq, busCmd}, {1'b1, INV});
    snpValid = 1; snpCmd = INV; snpAddr = 8'h62;
    @(posedge clk); @(negedge clk);
    snpValid = 0;
    glob[8'h62] = 16'hBEEF;
    holdGrant = 0;
    finishCore();
    chk(grantSeq == {4'b0, RD, INV}, "R12 re-read then invalidate", grantSeq, {RD, INV});
    coreOp(0, 8'h62, 0);
    chk(lastRd == 16'h7777, "R12 write landed", lastRd, 16'h7777);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op = $urandom % 10;
      logic [AW-1:0] a = AW'(($urandom % 3) * 16 + ($urandom % 4));
      logic [DW-1:0] v = DW'($urandom);
      if (op < 4) begin
        coreOp(0, a, 0);
        chk(lastRd == glob[a], "R2 random read coherent", lastRd, glob[a]);
      end else if (op < 7) coreOp(1, a, v);
      else if (op == 7) otherWrite(a, v);
      else if (op == 8) snoopOne(RD, a);
      else snoopOne(WB, a);
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule